// File: doc/BRIEF.md
# Packed Integer Compare-to-Mask Unit

This unit takes two packed integer vectors, splits them into lanes of 8, 16, 32 or 64 bits, and compares each pair of lanes under one of eight predicates picked by a 3-bit code. The result of lane i goes to bit i of an output bit mask, not into a vector of all-ones and all-zeros lanes. The compare is signed (two's complement) or unsigned, as a control input selects.

A second bit mask qualifies the result: a lane whose qualifier bit is 0 yields a 0. A separate bypass input turns qualification off, for the case where the caller names no mask. The vector width is a parameter, 512 bits by default, so the mask is VW/8 bits wide. Bits at or above the active lane count are always 0.

Operands enter on a valid/ready channel and results leave on a valid/ready channel. A word is accepted on a rising edge where `in_valid` and `in_ready` are both high. A result is consumed on a rising edge where `out_valid` and `out_ready` are both high. Once raised, `out_valid` and `res_mask` stay unchanged until the result is consumed. With the output register in place (`REG_OUT`=1) the unit holds one result, and `in_ready` is high when that slot is empty or is being drained in the same cycle. With `REG_OUT`=0 the unit is purely combinational: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

Top module: `vcm_top`

## Requirements
- R1: Predicate code 0 sets a lane's bit when its operands are equal, and code 4 sets it when they differ.
- R2: With `is_signed`=0, lanes compare as unsigned integers. Code 1 means a<b, 2 means a<=b, 5 means a>=b and 6 means a>b.
- R3: With `is_signed`=1, codes 1, 2, 5 and 6 compare the lanes as two's complement values. The most negative value orders below all-ones (-1).
- R4: Code 3 produces an all-zero mask, and code 7 sets every active, qualified lane bit.
- R5: `lane_sel` 0/1/2/3 selects 8/16/32/64-bit lanes. Lane i occupies operand bits [i*w +: w], and its result lands in `res_mask` bit i.
- R6: `res_mask` bits at index VW/w and above are 0 for every predicate.
- R7: With `qual_off`=0, a lane whose `qual_mask` bit is 0 gives 0. With `qual_off`=1, `qual_mask` has no effect.
- R8: With `REG_OUT`=1, an accepted word's result shows `out_valid` high in the cycle after acceptance. Results leave in acceptance order.
- R9: After reset, `out_valid` is low and `in_ready` is high.
- R10: While `out_valid` is high and `out_ready` is low, `res_mask` and `out_valid` hold, and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand word valid |
| in_ready | output | 1 | Unit can accept a word |
| op_a | input | VW | First packed operand |
| op_b | input | VW | Second packed operand |
| lane_sel | input | 2 | Lane width: 0=8, 1=16, 2=32, 3=64 bits |
| is_signed | input | 1 | 1 selects a two's complement compare |
| pred | input | 3 | Predicate code (0 eq, 1 lt, 2 le, 3 false, 4 ne, 5 nlt, 6 nle, 7 true) |
| qual_mask | input | VW/8 | Per-lane qualifier, bit i for lane i |
| qual_off | input | 1 | 1 disables qualification |
| out_valid | output | 1 | Result mask valid |
| out_ready | input | 1 | Consumer takes the result |
| res_mask | output | VW/8 | Per-lane compare result |

## Verification
The checker watches the mask before the output stage on every accepted word. It checks that bits above the active lane count stay clear, that an unqualified lane never reads 1, and that codes 3 and 7 yield an empty mask and a full active mask. It also checks that a stalled result holds and that an accepted word appears one cycle later. The ordering predicates, the signed and unsigned handling of boundary values, and the placement of each lane's bit can only be shown by the bench. It compares every result against an independent lane-by-lane model across all widths, both signednesses and all eight codes, under random back-pressure.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

  typedef enum logic [1:0] {
    LANE_8  = 2'd0,
    LANE_16 = 2'd1,
    LANE_32 = 2'd2,
    LANE_64 = 2'd3
  } lane_e;

  typedef enum logic [2:0] {
    PR_EQ    = 3'd0,
    PR_LT    = 3'd1,
    PR_LE    = 3'd2,
    PR_NONE  = 3'd3,
    PR_NE    = 3'd4,
    PR_NLT   = 3'd5,
    PR_NLE   = 3'd6,
    PR_ALL   = 3'd7
  } pred_e;

  localparam int NUM_WIDTHS = 4;

  // Map raw equality / less-than flags onto the selected predicate.
  function automatic logic pred_apply(input logic [2:0] p, input logic eq, input logic lt);
    logic r;
    unique case (pred_e'(p))
      PR_EQ:   r = eq;
      PR_LT:   r = lt;
      PR_LE:   r = lt | eq;
      PR_NONE: r = 1'b0;
      PR_NE:   r = ~eq;
      PR_NLT:  r = ~lt;
      PR_NLE:  r = ~(lt | eq);
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/vcm_lane_cmp.sv
// One lane: equality and less-than, signed or unsigned.
module vcm_lane_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sgn,
  output logic         eq,
  output logic         lt
);
  logic [W-1:0] a_bias, b_bias;

  // Flipping the sign bit turns a two's complement order into an unsigned one.
  always_comb begin
    a_bias        = a;
    b_bias        = b;
    a_bias[W-1]   = a[W-1] ^ sgn;
    b_bias[W-1]   = b[W-1] ^ sgn;
  end

  assign eq = (a == b);
  assign lt = (a_bias < b_bias);
endmodule

// File: rtl/vcm_width_bank.sv
// All lanes of one width; flags padded with zeros up to NL_MAX.
module vcm_width_bank #(
  parameter int VW     = 512,
  parameter int W      = 8,
  parameter int NL_MAX = VW / 8
) (
  input  logic [VW-1:0]     a,
  input  logic [VW-1:0]     b,
  input  logic              sgn,
  output logic [NL_MAX-1:0] eq_o,
  output logic [NL_MAX-1:0] lt_o
);
  localparam int NL = VW / W;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    vcm_lane_cmp #(.W(W)) u_cmp (
      .a  (a[i*W +: W]),
      .b  (b[i*W +: W]),
      .sgn(sgn),
      .eq (eq_o[i]),
      .lt (lt_o[i])
    );
  end

  if (NL < NL_MAX) begin : g_pad
    assign eq_o[NL_MAX-1:NL] = '0;
    assign lt_o[NL_MAX-1:NL] = '0;
  end
endmodule

// File: rtl/vcm_mask_form.sv
// Predicate, qualifier and active-lane trimming.
module vcm_mask_form #(
  parameter int NL_MAX = 64
) (
  input  logic [NL_MAX-1:0] eq,
  input  logic [NL_MAX-1:0] lt,
  input  logic [2:0]        pred,
  input  logic [1:0]        lane_sel,
  input  logic [NL_MAX-1:0] qual_mask,
  input  logic              qual_off,
  output logic [NL_MAX-1:0] mask_o
);
  import vcm_pkg::*;

  int unsigned              lanes;
  logic        [NL_MAX-1:0] qual;

  assign lanes = NL_MAX >> lane_sel;
  assign qual  = qual_off ? '1 : qual_mask;

  always_comb begin
    for (int i = 0; i < NL_MAX; i++) begin
      mask_o[i] = (i < lanes) & qual[i] & pred_apply(pred, eq[i], lt[i]);
    end
  end
endmodule

// File: rtl/vcm_out_stage.sv
// Output slot: a one-entry register or a plain pass-through.
module vcm_out_stage #(
  parameter int W   = 64,
  parameter bit REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);
  if (REG) begin : g_reg
    logic         full;
    logic [W-1:0] data;

    assign in_ready = ~full | out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full <= 1'b0;
        data <= '0;
      end else if (in_ready) begin
        full <= in_valid;
        if (in_valid) data <= d;
      end
    end

    assign out_valid = full;
    assign q         = data;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign q         = d;
  end
endmodule

// File: rtl/vcm_top.sv
// Packed integer compare into a per-lane bit mask. VW must be a multiple of 64.
module vcm_top #(
  parameter int VW      = 512,
  parameter bit REG_OUT = 1'b1,
  localparam int NL_MAX = VW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VW-1:0]     op_a,
  input  logic [VW-1:0]     op_b,
  input  logic [1:0]        lane_sel,
  input  logic              is_signed,
  input  logic [2:0]        pred,
  input  logic [NL_MAX-1:0] qual_mask,
  input  logic              qual_off,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NL_MAX-1:0] res_mask
);
  import vcm_pkg::*;

  logic [NL_MAX-1:0] eq_w [NUM_WIDTHS];
  logic [NL_MAX-1:0] lt_w [NUM_WIDTHS];
  logic [NL_MAX-1:0] eq_sel, lt_sel;
  logic [NL_MAX-1:0] cmp_mask;

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
    vcm_width_bank #(
      .VW    (VW),
      .W     (8 << g),
      .NL_MAX(NL_MAX)
    ) u_bank (
      .a   (op_a),
      .b   (op_b),
      .sgn (is_signed),
      .eq_o(eq_w[g]),
      .lt_o(lt_w[g])
    );
  end

  assign eq_sel = eq_w[lane_sel];
  assign lt_sel = lt_w[lane_sel];

  vcm_mask_form #(.NL_MAX(NL_MAX)) u_form (
    .eq       (eq_sel),
    .lt       (lt_sel),
    .pred     (pred),
    .lane_sel (lane_sel),
    .qual_mask(qual_mask),
    .qual_off (qual_off),
    .mask_o   (cmp_mask)
  );

  vcm_out_stage #(.W(NL_MAX), .REG(REG_OUT)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .d        (cmp_mask),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .q        (res_mask)
  );
endmodule

// File: rtl/vcm_chk.sv
module vcm_chk #(
  parameter int NL_MAX  = 64,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        lane_sel,
  input logic [2:0]        pred,
  input logic [NL_MAX-1:0] qual_mask,
  input logic              qual_off,
  input logic [NL_MAX-1:0] cmp_mask,
  input logic              out_valid,
  input logic              out_ready,
  input logic [NL_MAX-1:0] res_mask
);
  logic [NL_MAX-1:0] above_active;
  assign above_active = cmp_mask >> (NL_MAX >> lane_sel);

  AST_HIGH_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> above_active == '0); // R6

  AST_QUAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !qual_off) |-> (cmp_mask & ~qual_mask) == '0); // R7

  AST_CONST_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred == 3'd3) |-> cmp_mask == '0); // R4

  AST_CONST_TRUE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred == 3'd7 && qual_off) |-> $countones(cmp_mask) == (NL_MAX >> lane_sel)); // R4

  if (REG_OUT) begin : g_reg_props
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(res_mask))); // R10

    AST_STALL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready); // R10

    AST_ACCEPT_APPEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid); // R8
  end
endmodule

bind vcm_top vcm_chk #(.NL_MAX(NL_MAX), .REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .lane_sel (lane_sel),
  .pred     (pred),
  .qual_mask(qual_mask),
  .qual_off (qual_off),
  .cmp_mask (cmp_mask),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .res_mask (res_mask)
);

// File: tb/sim_vcm_top.sv
`timescale 1ns/1ps
module sim_vcm_top;
  localparam int VW  = 512;
  localparam int NLM = VW / 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n, in_valid, in_ready, is_signed, qual_off, out_valid, out_ready;
  logic [VW-1:0]  op_a, op_b;
  logic [1:0]     lane_sel;
  logic [2:0]     pred;
  logic [NLM-1:0] qual_mask, res_mask;

  vcm_top #(.VW(VW), .REG_OUT(1'b1)) u0 (.*);

  typedef struct {
    logic [NLM-1:0] m;
    string          tag;
  } item_t;
  item_t sb[$];

  int n_chk = 0, n_fail = 0;
  bit ready_rand = 1'b0;

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Lane-by-lane model written from the requirements.
  function automatic logic [NLM-1:0] model(logic [VW-1:0] a, logic [VW-1:0] b, int ls,
                                          bit sg, int p, logic [NLM-1:0] qm, bit qo);
    logic [NLM-1:0]    r;
    logic [63:0]       ua, ub;
    logic signed [65:0] sa, sb2;
    int w, nl;
    bit  c;
    r  = '0;
    w  = 8 << ls;
    nl = VW / w;
    for (int i = 0; i < nl; i++) begin
      ua = '0; ub = '0;
      for (int k = 0; k < w; k++) begin
        ua[k] = a[i*w+k];
        ub[k] = b[i*w+k];
      end
      sa  = {2'b00, ua};
      sb2 = {2'b00, ub};
      if (sg && ua[w-1]) sa  = sa  - (66'sd1 <<< w);
      if (sg && ub[w-1]) sb2 = sb2 - (66'sd1 <<< w);
      case (p)
        0: c = (sa == sb2);
        1: c = (sa <  sb2);
        2: c = (sa <= sb2);
        3: c = 1'b0;
        4: c = (sa != sb2);
        5: c = (sa >= sb2);
        6: c = (sa >  sb2);
        default: c = 1'b1;
      endcase
      r[i] = c & (qo | qm[i]);
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [VW-1:0] min_vec(int w);
    logic [VW-1:0] v;
    for (int i = 0; i < VW; i++) v[i] = ((i % w) == w - 1);
    return v;
  endfunction

  task automatic send(string tag, logic [VW-1:0] a, logic [VW-1:0] b, int ls, bit sg, int p,
                      logic [NLM-1:0] qm, bit qo);
    item_t it;
    @(negedge clk);
    in_valid  = 1'b1;
    op_a      = a;
    op_b      = b;
    lane_sel  = 2'(ls);
    is_signed = sg;
    pred      = 3'(p);
    qual_mask = qm;
    qual_off  = qo;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    it.m   = model(a, b, ls, sg, p, qm, qo);
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Consumer side: random back-pressure when enabled.
  initial begin
    forever begin
      @(negedge clk);
      if (ready_rand) out_ready = (($urandom % 4) != 0);
    end
  end

  // Monitor: a result is taken at the coming edge when valid and ready.
  initial begin
    item_t e;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check("R8", "unexpected result", 64'(res_mask), 64'hDEAD);
        end else begin
          e = sb.pop_front();
          check(e.tag, "mask", 64'(res_mask), 64'(e.m));
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  function automatic string tag_of(int p, bit sg);
    if (p == 0 || p == 4) return "R1";
    if (p == 3 || p == 7) return "R4";
    return sg ? "R3" : "R2";
  endfunction

  initial begin
    logic [NLM-1:0] held;
    logic [VW-1:0]  a, b;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    op_a = '0; op_b = '0; lane_sel = '0; is_signed = 1'b0; pred = '0;
    qual_mask = '0; qual_off = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R9", "out_valid after reset", 64'(out_valid), 64'd0);
    check("R9", "in_ready after reset", 64'(in_ready), 64'd1);

    // R10 / R8: stall with the consumer held off.
    out_ready = 1'b0;
    send("R10", rnd_vec(), rnd_vec(), 2, 1'b0, 6, '1, 1'b1);
    check("R8", "out_valid before accept", 64'(out_valid), 64'd0);
    @(negedge clk); in_valid = 1'b0; #1;
    check("R8", "out_valid after accept", 64'(out_valid), 64'd1);
    check("R10", "in_ready while full", 64'(in_ready), 64'd0);
    held = res_mask;
    repeat (3) @(negedge clk);
    #1;
    check("R10", "held result", 64'(res_mask), 64'(held));
    check("R10", "held valid", 64'(out_valid), 64'd1);
    ready_rand = 1'b1;

    // R5: lane placement, one differing lane per width.
    for (int ls = 0; ls < 4; ls++) begin
      a = '0;
      a[3 * (8 << ls)] = 1'b1;
      send("R5", a, '0, ls, 1'b0, 4, '0, 1'b1);
      send("R5", '0, a, ls, 1'b0, 1, '0, 1'b1);
    end

    // R6: always-true must stop at the active lane count.
    for (int ls = 0; ls < 4; ls++) send("R6", rnd_vec(), rnd_vec(), ls, 1'b1, 7, '1, 1'b1);

    // R7: qualifier applied, and ignored when bypassed.
    for (int ls = 0; ls < 4; ls++) begin
      send("R7", rnd_vec(), rnd_vec(), ls, 1'b0, 7, {$urandom, $urandom}, 1'b0);
      send("R7", rnd_vec(), rnd_vec(), ls, 1'b0, 7, '0, 1'b1);
      send("R7", rnd_vec(), rnd_vec(), ls, 1'b1, 5, {$urandom, $urandom}, 1'b0);
    end

    // R1-R4 sweep with boundary operand shapes.
    for (int ls = 0; ls < 4; ls++) begin
      for (int sg = 0; sg < 2; sg++) begin
        for (int p = 0; p < 8; p++) begin
          for (int k = 0; k < 5; k++) begin
            case (k)
              0: begin a = rnd_vec(); b = rnd_vec(); end
              1: begin a = rnd_vec(); b = a; b[VW-1 -: 64] = rnd_vec(); end
              2: begin a = min_vec(8 << ls); b = '1; end
              3: begin a = '1; b = '0; end
              default: begin a = rnd_vec(); b = min_vec(8 << ls); end
            endcase
            send(tag_of(p, bit'(sg)), a, b, ls, bit'(sg), p, {$urandom, $urandom}, ($urandom % 2) == 0);
          end
        end
      end
    end

    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < 200 && sb.size() != 0; i++) @(negedge clk);
    check("R8", "scoreboard drained", 64'(sb.size()), 64'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule